// File: doc/BRIEF.md
# Multi-channel compare-match timer

A bank of free-running timer channels that share one register bus. Each channel owns an up-counter, a compare value and a control/status word. A running channel advances its counter once every `DIV` clocks. When the counter equals the compare value on such an advance, the counter returns to zero and a sticky match flag is raised, so the channel produces a periodic event. A single run register, shared by every channel, starts and halts the channels one bit each. A per-channel interrupt line follows the match flag when that channel's interrupt enable is set.

The `WIDE` parameter selects the 16-bit or the 32-bit channel variant. The variant fixes the counter width, the byte stride between registers and the bit position of the status flags. The register bus has no back-pressure: a write is taken on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`, so every access completes in its own cycle.

Top module: `match_timer_bank`

## Requirements
- R1: After reset every run bit is 0, every counter is 0, every flag and interrupt enable is 0, and every compare register reads all ones.
- R2: The run register is at byte address 0. Channel n has its registers at `CH_BASE + n*CH_STRIDE + k*S`, where S is 2 in the 16-bit variant and 4 in the 32-bit variant. k=0 is control/status, k=1 is the counter and k=2 is the compare register.
- R3: Bit n of the run register starts channel n when 1 and halts it when 0. The register reads back its run bits. Bits at or above `NUM_CH` read as zero.
- R4: A running channel advances its counter by one every `DIV` clock cycles, wrapping from all ones to zero.
- R5: On an advance where the counter equals the compare value, the counter becomes zero and the match flag is set. The match flag is bit 7 in the 16-bit variant and bit 15 in the 32-bit variant. Counting then continues, so matches repeat.
- R6: A halted channel keeps both its counter value and its prescaler phase.
- R7: A compare write takes effect from the next cycle, even while the channel runs. If the new value is below the current count, the counter runs on to all ones, wraps to zero without a match, and then counts up to the new value.
- R8: A control/status write clears each of the two flag bits (7:6, or 15:14 in the 32-bit variant) where the written bit is 0 and leaves it unchanged where the written bit is 1. Bit 5 takes the written value as the interrupt enable. A match on the same edge as a clear leaves the match flag set.
- R9: The overrun flag, one bit below the match flag, is set when a match occurs while the match flag is already set.
- R10: Each channel's `irq` output is high exactly while both its match flag and its interrupt enable are 1. It stays high until software clears the flag or the enable.
- R11: Counter and compare registers take the written value. A counter write overrides an advance on the same edge. In the 32-bit variant, run and control/status writes use only data bits 15:0.
- R12: Reserved control/status bits read as zero. Reads from unmapped addresses return zero. Writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero-extended |
| irq | output | NUM_CH | Per-channel interrupt, flag AND enable |

## Verification
The bench builds the 16-bit variant with three channels, a channel base of 0x10, a stride of 0x10 and the default divide-by-8. The narrow counter lets a counter preset just under all ones reach the wrap within about a hundred cycles. That puts the lowered-compare and wrap-without-match path of R7 in reach, along with repeated matches for the overrun flag. The third channel puts a run bit above bit 1 and masks writes of all ones to the run register. A clear held on every cycle across a match edge covers set-over-clear precedence. The 32-bit default is covered only by elaboration and by the bound checker.

// File: rtl/mtb_pkg.sv
package mtb_pkg;

  // Register index inside one channel window.
  typedef enum logic [1:0] {
    RG_CSR  = 2'd0,
    RG_CNT  = 2'd1,
    RG_CMP  = 2'd2,
    RG_NONE = 2'd3
  } reg_sel_e;

  // Interrupt-enable position in the control/status word (both variants).
  localparam int IE_BIT = 5;

  // Number of registers in one channel window.
  localparam int REGS_PER_CH = 3;

  function automatic int flag_pos(input bit wide);
    return wide ? 15 : 7;
  endfunction

  function automatic int stride_shift(input bit wide);
    return wide ? 2 : 1;
  endfunction

endpackage

// File: rtl/mtb_decode.sv
module mtb_decode
  import mtb_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int ADDR_W    = 8,
  parameter int CH_BASE   = 16,
  parameter int CH_STRIDE = 16,
  parameter int REG_SH    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_run,
  output logic [NUM_CH-1:0] ch_hit,
  output reg_sel_e          rsel
);

  localparam int WIN   = REGS_PER_CH << REG_SH;
  localparam int ALIGN = 1 << REG_SH;

  always_comb begin
    int off;
    hit_run = (addr == '0);
    ch_hit  = '0;
    rsel    = RG_NONE;
    off     = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      off = int'(addr) - (CH_BASE + i * CH_STRIDE);
      if (off >= 0 && off < WIN && (off % ALIGN) == 0) begin
        ch_hit[i] = 1'b1;
        rsel      = reg_sel_e'(2'(off >> REG_SH));
      end
    end
  end

endmodule

// File: rtl/mtb_tick.sv
module mtb_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  // Phase only moves while running, so a halt preserves it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (run)
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign tick = run && (phase_q == LAST);

endmodule

// File: rtl/mtb_channel.sv
module mtb_channel
  import mtb_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DIV     = 8,
  parameter int FLAG_HI = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_csr,
  input  logic             wr_cnt,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic [15:0]      csr_rd,
  output logic             flag,
  output logic             ie,
  output logic             irq
);

  localparam int OVR_BIT = FLAG_HI - 1;

  logic tick;
  logic hit;
  logic clr_flag, clr_ovr;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic flag_q, ovr_q, ie_q;

  mtb_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  assign hit      = tick && (cnt_q == cmp_q);
  assign clr_flag = wr_csr && !wdata[FLAG_HI];
  assign clr_ovr  = wr_csr && !wdata[OVR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '1;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      // Software write beats an advance on the same edge.
      if (wr_cnt)
        cnt_q <= wdata;
      else if (tick)
        cnt_q <= hit ? '0 : cnt_q + 1'b1;

      if (wr_cmp)
        cmp_q <= wdata;

      // A hardware match wins over a clear on the same edge.
      flag_q <= hit | (flag_q & ~clr_flag);
      ovr_q  <= (hit & flag_q) | (ovr_q & ~clr_ovr);

      if (wr_csr)
        ie_q <= wdata[IE_BIT];
    end
  end

  always_comb begin
    csr_rd          = '0;
    csr_rd[FLAG_HI] = flag_q;
    csr_rd[OVR_BIT] = ovr_q;
    csr_rd[IE_BIT]  = ie_q;
  end

  assign cnt  = cnt_q;
  assign cmp  = cmp_q;
  assign flag = flag_q;
  assign ie   = ie_q;
  assign irq  = flag_q & ie_q;

endmodule

// File: rtl/match_timer_bank.sv
module match_timer_bank
  import mtb_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter bit WIDE      = 1'b1,
  parameter int DIV       = 8,
  parameter int ADDR_W    = 8,
  parameter int CH_BASE   = 16,
  parameter int CH_STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int CNT_W   = WIDE ? 32 : 16;
  localparam int REG_SH  = stride_shift(WIDE);
  localparam int FLAG_HI = flag_pos(WIDE);

  logic                         hit_run;
  logic [NUM_CH-1:0]            ch_hit;
  reg_sel_e                     rsel;
  logic                         bus_we;
  logic [NUM_CH-1:0]            run_q;
  logic [NUM_CH-1:0]            wr_csr_v, wr_cnt_v, wr_cmp_v;
  logic [NUM_CH-1:0]            flag_v, ie_v;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v, cmp_v;
  logic [NUM_CH-1:0][15:0]      csr_v;

  mtb_decode #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .CH_BASE  (CH_BASE),
    .CH_STRIDE(CH_STRIDE),
    .REG_SH   (REG_SH)
  ) u_dec (
    .addr   (bus_addr),
    .hit_run(hit_run),
    .ch_hit (ch_hit),
    .rsel   (rsel)
  );

  assign bus_we = bus_sel && bus_wr;

  // Shared run register: one bit per channel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (bus_we && hit_run)
      run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wr_csr_v[i] = bus_we && ch_hit[i] && (rsel == RG_CSR);
    assign wr_cnt_v[i] = bus_we && ch_hit[i] && (rsel == RG_CNT);
    assign wr_cmp_v[i] = bus_we && ch_hit[i] && (rsel == RG_CMP);

    mtb_channel #(
      .CNT_W  (CNT_W),
      .DIV    (DIV),
      .FLAG_HI(FLAG_HI)
    ) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q[i]),
      .wr_csr(wr_csr_v[i]),
      .wr_cnt(wr_cnt_v[i]),
      .wr_cmp(wr_cmp_v[i]),
      .wdata (bus_wdata[CNT_W-1:0]),
      .cnt   (cnt_v[i]),
      .cmp   (cmp_v[i]),
      .csr_rd(csr_v[i]),
      .flag  (flag_v[i]),
      .ie    (ie_v[i]),
      .irq   (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_run)
      bus_rdata[NUM_CH-1:0] = run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (rsel)
          RG_CSR:  bus_rdata[15:0]      = csr_v[i];
          RG_CNT:  bus_rdata[CNT_W-1:0] = cnt_v[i];
          RG_CMP:  bus_rdata[CNT_W-1:0] = cmp_v[i];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mtb_chk.sv
module mtb_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            run_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_CH-1:0]            flag_v,
  input logic [NUM_CH-1:0]            wr_cnt_v,
  input logic [NUM_CH-1:0]            wr_csr_v,
  input logic [NUM_CH-1:0]            irq
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && !wr_cnt_v[i]) |=> $stable(cnt_v[i]));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt_v[i]) && !$past(wr_cnt_v[i])) |->
        ((cnt_v[i] == CNT_W'($past(cnt_v[i]) + 1'b1)) || (cnt_v[i] == '0)));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_v[i]) && !$past(wr_cnt_v[i])) |-> (cnt_v[i] == '0));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_v[i]) |-> $past(wr_csr_v[i]));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !wr_csr_v[i]) |=> irq[i]);
  end

endmodule

bind match_timer_bank mtb_chk #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_q   (run_q),
  .cnt_v   (cnt_v),
  .flag_v  (flag_v),
  .wr_cnt_v(wr_cnt_v),
  .wr_csr_v(wr_csr_v),
  .irq     (irq)
);

// File: tb/match_timer_bank_tb_top.sv
module match_timer_bank_tb_top;

  localparam int NCH  = 3;
  localparam int DIV  = 8;
  localparam int BASE = 16;
  localparam int STR  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;

  // 8 time units per period: 125 MHz with 1 ns units.
  always #4 clk = ~clk;

  match_timer_bank #(
    .NUM_CH   (NCH),
    .WIDE     (1'b0),
    .DIV      (DIV),
    .ADDR_W   (8),
    .CH_BASE  (BASE),
    .CH_STRIDE(STR)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0]    m_cnt [NCH];
  logic [15:0]    m_cmp [NCH];
  int             m_pre [NCH];
  logic           m_flag[NCH];
  logic           m_ovr [NCH];
  logic           m_ie  [NCH];
  logic [NCH-1:0] m_run;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = '0;
      for (int i = 0; i < NCH; i++) begin
        m_cnt[i] = 16'h0; m_cmp[i] = 16'hFFFF; m_pre[i] = 0;
        m_flag[i] = 1'b0; m_ovr[i] = 1'b0; m_ie[i] = 1'b0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        int   b;
        logic we, tk, mt, old_flag;
        b  = BASE + STR * i;
        we = bus_sel && bus_wr;
        tk = m_run[i] && (m_pre[i] == DIV - 1);
        mt = tk && (m_cnt[i] == m_cmp[i]);
        old_flag = m_flag[i];
        if (m_run[i]) m_pre[i] = (m_pre[i] == DIV - 1) ? 0 : m_pre[i] + 1;
        if (we && int'(bus_addr) == b + 2) m_cnt[i] = bus_wdata[15:0];
        else if (tk) m_cnt[i] = mt ? 16'h0 : m_cnt[i] + 16'h1;
        if (we && int'(bus_addr) == b + 4) m_cmp[i] = bus_wdata[15:0];
        if (we && int'(bus_addr) == b) begin
          m_flag[i] = m_flag[i] & bus_wdata[7];
          m_ovr[i]  = m_ovr[i] & bus_wdata[6];
          m_ie[i]   = bus_wdata[5];
        end
        if (mt) begin
          m_flag[i] = 1'b1;
          if (old_flag) m_ovr[i] = 1'b1;
        end
      end
      if (bus_sel && bus_wr && bus_addr == 8'h00) m_run = bus_wdata[NCH-1:0];
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 8'h00) r[NCH-1:0] = m_run;
    for (int i = 0; i < NCH; i++) begin
      int b;
      b = BASE + STR * i;
      if (int'(a) == b)     r = {24'h0, m_flag[i], m_ovr[i], m_ie[i], 5'h0};
      if (int'(a) == b + 2) r = {16'h0, m_cnt[i]};
      if (int'(a) == b + 4) r = {16'h0, m_cmp[i]};
    end
    return r;
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    if (a == 8'h00) return "R3 run reg";
    for (int i = 0; i < NCH; i++) begin
      int b;
      b = BASE + STR * i;
      if (int'(a) == b)     return "R8 ctrl/status";
      if (int'(a) == b + 2) return "R4 counter";
      if (int'(a) == b + 4) return "R7 compare";
    end
    return "R12 unmapped";
  endfunction

  function automatic logic [NCH-1:0] model_irq();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = m_flag[i] & m_ie[i];
    return v;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Every clock, away from the edge: compare outputs with the model.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check("R10 irq lines", 32'(irq), 32'(model_irq()));
      check(read_tag(bus_addr), bus_rdata, model_read(bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=150000 expected<150000 cycles");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v, v2;
    idle(4);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rd(8'h00, v); check("R1 run reg after reset", v, 32'h0);
    rd(8'h10, v); check("R1 csr0 after reset", v, 32'h0);
    rd(8'h12, v); check("R1 cnt0 after reset", v, 32'h0);
    rd(8'h14, v); check("R1 cmp0 after reset", v, 32'hFFFF);
    rd(8'h34, v); check("R1 cmp2 after reset", v, 32'hFFFF);

    // R2 address map, compare per channel
    wr(8'h14, 32'h4); wr(8'h24, 32'h9); wr(8'h34, 32'h3);
    rd(8'h14, v); check("R2 cmp ch0", v, 32'h4);
    rd(8'h24, v); check("R2 cmp ch1", v, 32'h9);
    rd(8'h34, v); check("R2 cmp ch2", v, 32'h3);

    // R12 unmapped reads and writes
    rd(8'h16, v); check("R12 unmapped read 0x16", v, 32'h0);
    rd(8'h02, v); check("R12 unmapped read 0x02", v, 32'h0);
    wr(8'h16, 32'hFFFF); wr(8'h02, 32'h1);
    rd(8'h14, v); check("R12 cmp ch0 untouched", v, 32'h4);
    rd(8'h00, v); check("R12 run reg untouched", v, 32'h0);

    // R8 writing ones does not set flags; enable taken
    wr(8'h10, 32'h00E0);
    rd(8'h10, v); check("R8 csr0 ones keep flags clear", v, 32'h20);

    // R4 R5 run channel 0, compare 4 (period 40 clocks)
    wr(8'h00, 32'h1);
    idle(20);
    rd(8'h12, v); check("R4 counter pace", v, model_read(8'h12));
    idle(80);
    // R9 two matches since enable -> both flags
    rd(8'h10, v); check("R9 overrun after second match", v, 32'hE0);
    check("R10 irq0 high", 32'(irq[0]), 32'h1);
    check("R5 counter periodic", 32'(dut_i.bus_rdata), model_read(8'h10));

    // R8 clear held across a match edge: set wins
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h20;
    idle(50);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h10, v); check("R8 flag after held clear", v, model_read(8'h10));

    // R6 halt keeps count and phase
    wr(8'h00, 32'h0);
    rd(8'h12, v);
    idle(30);
    rd(8'h12, v2); check("R6 count held while halted", v2, v);

    // R11 counter write while halted
    wr(8'h12, 32'h2);
    rd(8'h12, v); check("R11 counter write", v, 32'h2);
    wr(8'h00, 32'h1);
    idle(10);
    rd(8'h12, v); check("R6 phase kept after restart", v, model_read(8'h12));

    // R11 counter write while running
    wr(8'h12, 32'h100);
    rd(8'h12, v); check("R11 counter write while running", v, model_read(8'h12));

    // R7 count above compare on ch1: wrap without match
    wr(8'h22, 32'hFFF0);
    wr(8'h00, 32'h3);
    idle(140);
    rd(8'h20, v); check("R7 no match across wrap", v, 32'h0);
    rd(8'h22, v); check("R7 counter after wrap", v, model_read(8'h22));
    idle(80);
    rd(8'h20, v); check("R7 match after wrap", v, model_read(8'h20));
    wr(8'h24, 32'h1);
    idle(40);
    rd(8'h20, v); check("R7 lowered compare while running", v, model_read(8'h20));

    // R3 all ones to run reg, upper bits read zero
    wr(8'h00, 32'hFFFF);
    rd(8'h00, v); check("R3 run reg masked", v, 32'h7);
    idle(100);
    rd(8'h30, v); check("R9 ch2 flags without enable", v, 32'hC0);
    check("R10 irq2 low without enable", 32'(irq[2]), 32'h0);

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule